// File: doc/BRIEF.md
# Interrupt Rate Limiter with Storm Detection

This block stands between a peripheral's raw event line and the interrupt line of a processor. Every event marks a sticky pending flag. The block raises a level interrupt for a pending event only after a programmable quiet interval has passed since the last acknowledge. The interrupt then holds until software acknowledges it. Events that arrive during the quiet interval are kept as pending and are signalled once the interval runs out.

The block also counts events over a measurement window of programmable length. At the end of each window it compares the count with a programmable threshold. A count above the threshold puts the block into polling mode. In polling mode the interrupt line is held low, while the pending flag and the status word stay readable so that software can poll them on its own schedule. A later window whose count is at or below the threshold returns the block to interrupt mode.

Configuration uses a small register port with a write strobe, a two-bit address and a combinational read.

Top module: `irq_throttle`

## Requirements
- R1: After reset, `irq_o`, `pend_o` and `poll_mode_o` are 0 and the status word reads 0. The gap, window and threshold registers read their reset parameters (defaults 4, 64 and 32).
- R2: The register map is: address 0 is the gap in cycles, address 1 is the window length in cycles, and address 2 is the threshold. Each of these reads back the value last written to it.
- R3: A write to address 3 is an acknowledge. It clears `irq_o` and the pending flag on that edge. In interrupt mode, `irq_o` rises when the pending flag is set and the gap has expired, and it stays high until an acknowledge.
- R4: An acknowledge with gap value G keeps `irq_o` low for the G+1 sampled cycles that follow the acknowledge edge. With G = 0, a request that is still pending raises `irq_o` on the very next edge.
- R5: An event during the gap sets the pending flag, and the flag holds until an acknowledge. When the gap expires, the held event raises `irq_o`.
- R6: When an event and an acknowledge fall in the same cycle, the pending flag stays set after that edge, so the event is not lost.
- R7: A window of length W (0 is treated as 1) covers the W cycles that follow a write to address 1, or that follow the previous window end. Reading address 3 gives a status word. Bit 0 is the mode (1 means polling). Bit 1 is the pending flag. Bits [9:2] hold the event count of the last completed window, which saturates at 255.
- R8: At a window end whose count is above the threshold, the block enters polling mode. In polling mode `irq_o` is 0 from that same edge onward.
- R9: In polling mode, events still set `pend_o` and status bit 1, and an acknowledge clears them, while `irq_o` stays 0.
- R10: At a window end whose count is at or below the threshold, the block returns to interrupt mode. A request that is still pending then raises `irq_o` on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 1 | Raw event request, one event per cycle it is high |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address, used for both write and read |
| reg_wdata_i | input | DW (16) | Register write data |
| reg_rdata_o | output | DW (16) | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt to the processor |
| pend_o | output | 1 | Sticky pending flag |
| poll_mode_o | output | 1 | 1 while the block is in polling mode |

## Verification
A new event and the software acknowledge can arrive on the same edge. The bench provokes this by raising `evt_i` in the same cycle as the write to address 3, both while an interrupt is outstanding and with a gap of zero. It judges the outcome by three observations: the pending flag must survive that edge, `irq_o` must fall on it, and `irq_o` must rise again exactly G+1 cycles later. A second overlap occurs when a window ends while an interrupt is already high. The check there is that `irq_o` drops on the same edge at which the mode bit turns to polling.

// File: rtl/irq_throttle_pkg.sv
package irq_throttle_pkg;

   typedef enum logic [1:0] {
      SEL_GAP    = 2'd0,
      SEL_WINDOW = 2'd1,
      SEL_THRESH = 2'd2,
      SEL_CTRL   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irqt_regs.sv
module irqt_regs
   import irq_throttle_pkg::*;
#(
   parameter int DW      = 16,
   parameter int GAP_RST = 4,
   parameter int WIN_RST = 64,
   parameter int THR_RST = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [1:0]    addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] status_i,
   output logic [DW-1:0] gap_o,
   output logic [DW-1:0] win_o,
   output logic [DW-1:0] thr_o,
   output logic          ack_o,
   output logic          restart_o,
   output logic [DW-1:0] rdata_o
);

   reg_sel_e sel;
   assign sel = reg_sel_e'(addr_i);

   assign ack_o     = wr_i && (sel == SEL_CTRL);
   assign restart_o = wr_i && (sel == SEL_WINDOW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_o <= DW'(GAP_RST);
         win_o <= DW'(WIN_RST);
         thr_o <= DW'(THR_RST);
      end else if (wr_i) begin
         case (sel)
            SEL_GAP:    gap_o <= wdata_i;
            SEL_WINDOW: win_o <= wdata_i;
            SEL_THRESH: thr_o <= wdata_i;
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_GAP:    rdata_o = gap_o;
         SEL_WINDOW: rdata_o = win_o;
         SEL_THRESH: rdata_o = thr_o;
         default:    rdata_o = status_i;
      endcase
   end

endmodule

// File: rtl/irqt_rate_mon.sv
module irqt_rate_mon #(
   parameter int DW    = 16,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_i,
   input  logic             restart_i,
   input  logic [DW-1:0]    win_len_i,
   input  logic [DW-1:0]    thr_i,
   output logic             poll_o,
   output logic [CNT_W-1:0] last_cnt_o
);

   localparam int PAD = DW - CNT_W;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [DW-1:0]    win_cnt;
   logic [CNT_W-1:0] req_cnt;
   logic [CNT_W-1:0] req_sum;
   logic             at_end;
   logic             over;

   always_comb begin
      req_sum = (req_cnt == CNT_MAX) ? CNT_MAX : req_cnt + CNT_W'(evt_i);
      at_end  = (win_len_i <= DW'(1)) || (win_cnt >= win_len_i - DW'(1));
      over    = {{PAD{1'b0}}, req_sum} > thr_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_cnt    <= '0;
         req_cnt    <= '0;
         last_cnt_o <= '0;
         poll_o     <= 1'b0;
      end else if (restart_i) begin
         win_cnt <= '0;
         req_cnt <= '0;
      end else if (at_end) begin
         win_cnt    <= '0;
         req_cnt    <= '0;
         last_cnt_o <= req_sum;
         poll_o     <= over;
      end else begin
         win_cnt <= win_cnt + DW'(1);
         req_cnt <= req_sum;
      end
   end

   // R8
   mode_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !at_end |=> $stable(poll_o));

   // R7
   count_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !at_end |=> $stable(last_cnt_o));

endmodule

// File: rtl/irqt_gap_gen.sv
module irqt_gap_gen #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_i,
   input  logic          ack_i,
   input  logic          poll_i,
   input  logic [DW-1:0] gap_i,
   output logic          irq_o,
   output logic          pend_o
);

   logic [DW-1:0] gap_cnt;
   logic          irq_q;
   logic          pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_cnt <= '0;
         irq_q   <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         pend_q <= evt_i || (pend_q && !ack_i);
         irq_q  <= !ack_i && !poll_i && (irq_q || (pend_q && gap_cnt == '0));
         if (ack_i)
            gap_cnt <= gap_i;
         else if (gap_cnt != '0)
            gap_cnt <= gap_cnt - DW'(1);
      end
   end

   assign irq_o  = irq_q && !poll_i;
   assign pend_o = pend_q;

   // R3
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q && !ack_i && !poll_i |=> irq_q);

   // R4
   gap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt != '0 |=> !$rose(irq_q));

   // R5
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !ack_i |=> pend_q);

   // R6
   pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i && ack_i |=> pend_q && !irq_q);

   // R9
   poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_i |=> !irq_q);

endmodule

// File: rtl/irq_throttle.sv
module irq_throttle #(
   parameter int DW      = 16,
   parameter int CNT_W   = 8,
   parameter int GAP_RST = 4,
   parameter int WIN_RST = 64,
   parameter int THR_RST = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_i,
   input  logic          reg_wr_i,
   input  logic [1:0]    reg_addr_i,
   input  logic [DW-1:0] reg_wdata_i,
   output logic [DW-1:0] reg_rdata_o,
   output logic          irq_o,
   output logic          pend_o,
   output logic          poll_mode_o
);

   if (CNT_W < 1 || CNT_W + 2 > DW) begin : g_bad_cnt_w
      $error("irq_throttle: CNT_W must fit in the status word beside two flags");
   end
   if (GAP_RST >= (1 << DW) || WIN_RST >= (1 << DW) || THR_RST >= (1 << DW)) begin : g_bad_rst
      $error("irq_throttle: a reset value does not fit in DW bits");
   end

   logic [DW-1:0]    gap_val;
   logic [DW-1:0]    win_val;
   logic [DW-1:0]    thr_val;
   logic             ack;
   logic             restart;
   logic [CNT_W-1:0] last_cnt;
   logic [DW-1:0]    status;

   assign status = DW'({last_cnt, pend_o, poll_mode_o});

   irqt_regs #(
      .DW(DW), .GAP_RST(GAP_RST), .WIN_RST(WIN_RST), .THR_RST(THR_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr_i),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .status_i  (status),
      .gap_o     (gap_val),
      .win_o     (win_val),
      .thr_o     (thr_val),
      .ack_o     (ack),
      .restart_o (restart),
      .rdata_o   (reg_rdata_o)
   );

   irqt_rate_mon #(
      .DW(DW), .CNT_W(CNT_W)
   ) u_rate (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt_i),
      .restart_i  (restart),
      .win_len_i  (win_val),
      .thr_i      (thr_val),
      .poll_o     (poll_mode_o),
      .last_cnt_o (last_cnt)
   );

   irqt_gap_gen #(
      .DW(DW)
   ) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_i),
      .ack_i  (ack),
      .poll_i (poll_mode_o),
      .gap_i  (gap_val),
      .irq_o  (irq_o),
      .pend_o (pend_o)
   );

   // R8
   poll_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(poll_mode_o) |-> !irq_o);

   // R3
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_i && reg_addr_i == 2'd3 && !evt_i |=> !irq_o && !pend_o);

endmodule

// File: tb/irq_throttle_bench.sv
module irq_throttle_bench;

   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_i = 1'b0;
   logic          reg_wr_i = 1'b0;
   logic [1:0]    reg_addr_i = 2'd0;
   logic [DW-1:0] reg_wdata_i = '0;
   logic [DW-1:0] reg_rdata_o;
   logic          irq_o;
   logic          pend_o;
   logic          poll_mode_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_throttle u_irq_throttle (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt_i),
      .reg_wr_i    (reg_wr_i),
      .reg_addr_i  (reg_addr_i),
      .reg_wdata_i (reg_wdata_i),
      .reg_rdata_o (reg_rdata_o),
      .irq_o       (irq_o),
      .pend_o      (pend_o),
      .poll_mode_o (poll_mode_o)
   );

   // {write, addr, data, expected readback}
   localparam logic [34:0] VEC_TBL [0:5] = '{
      {1'b1, 2'd0, 16'd2,   16'd2},
      {1'b0, 2'd0, 16'd0,   16'd2},
      {1'b1, 2'd1, 16'd20,  16'd20},
      {1'b1, 2'd2, 16'd100, 16'd100},
      {1'b0, 2'd1, 16'd0,   16'd20},
      {1'b0, 2'd2, 16'd0,   16'd100}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d, input logic with_evt);
      reg_wr_i    = 1'b1;
      reg_addr_i  = a;
      reg_wdata_i = d;
      evt_i       = with_evt;
      step();
      reg_wr_i = 1'b0;
      evt_i    = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output int v);
      reg_addr_i = a;
      #1;
      v = int'(reg_rdata_o);
   endtask

   task automatic pulse();
      evt_i = 1'b1;
      step();
      evt_i = 1'b0;
   endtask

   initial begin
      int v;
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      chk("R1 irq", int'(irq_o), 0);
      chk("R1 pend", int'(pend_o), 0);
      chk("R1 mode", int'(poll_mode_o), 0);
      rd_reg(2'd3, v); chk("R1 status", v, 0);
      rd_reg(2'd0, v); chk("R1 gap reset", v, 4);
      rd_reg(2'd1, v); chk("R1 window reset", v, 64);
      rd_reg(2'd2, v); chk("R1 thresh reset", v, 32);

      // R2 register table
      for (int i = 0; i < 6; i++) begin
         if (VEC_TBL[i][34]) wr_reg(VEC_TBL[i][33:32], VEC_TBL[i][31:16], 1'b0);
         rd_reg(VEC_TBL[i][33:32], v);
         chk("R2 readback", v, int'(VEC_TBL[i][15:0]));
      end

      // R3 level interrupt, gap 2
      pulse();
      chk("R5 pend set", int'(pend_o), 1);
      chk("R3 irq not yet", int'(irq_o), 0);
      step();
      chk("R3 irq rises", int'(irq_o), 1);
      step(); step();
      chk("R3 irq holds", int'(irq_o), 1);
      wr_reg(2'd3, '0, 1'b0);
      chk("R3 ack clears irq", int'(irq_o), 0);
      chk("R3 ack clears pend", int'(pend_o), 0);
      // R4 / R5 event inside the gap
      pulse();
      chk("R5 held in gap", int'(pend_o), 1);
      step();
      chk("R4 gap blocks irq", int'(irq_o), 0);
      step();
      chk("R5 irq after gap", int'(irq_o), 1);

      // R6 event with acknowledge
      wr_reg(2'd3, '0, 1'b1);
      chk("R6 pend survives", int'(pend_o), 1);
      chk("R6 irq cleared", int'(irq_o), 0);
      step(); step();
      chk("R6 gap blocks", int'(irq_o), 0);
      step();
      chk("R6 irq returns", int'(irq_o), 1);
      wr_reg(2'd3, '0, 1'b0);
      chk("R3 pend cleared", int'(pend_o), 0);

      // R4 gap zero
      wr_reg(2'd0, 16'd0, 1'b0);
      pulse();
      step();
      chk("R4 gap0 first irq", int'(irq_o), 1);
      wr_reg(2'd3, '0, 1'b1);
      chk("R4 gap0 ack edge", int'(irq_o), 0);
      step();
      chk("R4 gap0 next cycle", int'(irq_o), 1);
      wr_reg(2'd3, '0, 1'b0);

      // R8 storm: 5 events in a 10-cycle window, threshold 3
      wr_reg(2'd2, 16'd3, 1'b0);
      wr_reg(2'd1, 16'd10, 1'b0);
      for (int i = 0; i < 10; i++) begin
         evt_i = (i % 2 == 0);
         step();
      end
      evt_i = 1'b0;
      chk("R8 poll mode", int'(poll_mode_o), 1);
      chk("R8 irq off", int'(irq_o), 0);
      rd_reg(2'd3, v); chk("R7 status count 5", v, 5 * 4 + 2 + 1);

      // R9 polling keeps pend visible
      wr_reg(2'd3, '0, 1'b0);
      chk("R9 ack in poll", int'(pend_o), 0);
      pulse();
      pulse();
      chk("R9 pend visible", int'(pend_o), 1);
      chk("R9 no irq", int'(irq_o), 0);
      rd_reg(2'd3, v); chk("R9 status pend bit", v & 3, 3);
      repeat (7) step();

      // R10 back to interrupt mode
      chk("R10 mode back", int'(poll_mode_o), 0);
      rd_reg(2'd3, v); chk("R10 status count 2", v, 2 * 4 + 2);
      step();
      chk("R10 irq resumes", int'(irq_o), 1);
      wr_reg(2'd3, '0, 1'b0);

      // R7 saturation of the window count
      wr_reg(2'd1, 16'd300, 1'b0);
      evt_i = 1'b1;
      repeat (300) step();
      evt_i = 1'b0;
      rd_reg(2'd3, v); chk("R7 saturated status", v, 255 * 4 + 2 + 1);
      chk("R8 poll after flood", int'(poll_mode_o), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all requirements act=hung exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule